// File: doc/BRIEF.md
# Flash Command Sequencer with Register Front End

This block sits between a simple 32-bit register bus and an embedded flash array. Software unlocks it with a key, enables writing, loads a target address, and then starts either a page erase or a single-word program. The block checks the loaded address against the array bounds and against a per-page protection map. It refuses any operation on a bad or protected page and reports the reason in status flags. While an operation is in progress it holds a busy flag for a fixed number of cycles.

A behavioural flash array is part of the block. Erase sets every word of a page to all ones. Programming can only clear bits, so the new word is the old word ANDed with the data. After each completed word program the target address steps forward by one word, so a run of words can be programmed without reloading the address.

A separate read port returns any word of the array. Page size, page count and the two busy durations are parameters.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status register (offset 0x01C) reads 0x8, the lock register (offset 0x03C) reads 1 (frozen) and the write-control register (offset 0x008) reads 0.
- R2: Writing 0x1B71 to bits [15:0] of the lock register unfreezes the block, and the lock register then reads 0. Any other value freezes it again, and the lock register then reads 1. While the block is frozen, writes to write-control, command (0x00C), address buffer (0x010) and write data (0x018) have no effect.
- R3: Bit 0 of write-control is the write enable and reads back in bit 0. While it is 0, erase and program commands do not start.
- R4: Command bit 0 copies the address buffer, with its two low bits cleared, into the internal address and sets the status flags. Status bit 2 (invalid) is set when the address is at or beyond NUM_PAGES*PAGE_WORDS*4. Status bit 1 (locked) is set when the address is valid and the bit of the page-permission input for its page is 0.
- R5: An erase or program issued while status bit 1 or bit 2 is set does not start, and it leaves the status unchanged.
- R6: Command bit 1 starts a page erase. Busy (status bit 0) is then high for exactly ERASE_CYC cycles, after which every word of the page holding the internal address reads 0xFFFFFFFF.
- R7: Command bit 3 starts a word program. Busy is then high for exactly PROG_CYC cycles, after which the addressed word holds its old value ANDed with the write-data register.
- R8: Status bit 3 (write-data ready) is the inverse of busy. Commands issued while busy have no effect.
- R9: After each completed word program the internal address grows by 4, and the invalid and locked flags are evaluated again for the new address.
- R10: A command write with bit 0 set performs only the address load. If bits 1 and 3 are both set, only the erase starts.
- R11: Status bits 5:4 read 0. The command register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus write strobe qualifier |
| bus_we | input | 1 | Write when high together with bus_en |
| bus_addr | input | BUS_AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| page_wr_ok | input | NUM_PAGES | Per-page permission, 1 = writable, 0 = protected |
| arr_raddr | input | log2(NUM_PAGES*PAGE_WORDS) | Word index for array readout |
| arr_rdata | output | 32 | Array word at arr_raddr |

## Verification
Erase and program are exercised on a writable page with an unaligned address, so the load must drop the low bits. Two successive programs without a reload expose the auto-increment, and a reprogram with a mask shows the AND behaviour that separates real flash from a plain RAM. Addresses are tried just inside the array end, just past it, and inside a protected page, which separates the invalid flag from the locked flag. A program of the last word before a protected page shows that the flags are evaluated again after the step. Commands sent during busy, with write enable clear, while frozen, and with several command bits in one write each leave a distinct trace in the status or the array if they are handled wrongly.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;
  localparam logic [7:0] OFS_WCTRL  = 8'h08;
  localparam logic [7:0] OFS_CMD    = 8'h0C;
  localparam logic [7:0] OFS_ADDRB  = 8'h10;
  localparam logic [7:0] OFS_WDATA  = 8'h18;
  localparam logic [7:0] OFS_STATUS = 8'h1C;
  localparam logic [7:0] OFS_LOCK   = 8'h3C;

  localparam logic [15:0] UNLOCK_KEY = 16'h1B71;

  localparam int CMD_LOAD  = 0;
  localparam int CMD_ERASE = 1;
  localparam int CMD_PROG  = 3;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2
  } flash_op_e;
endpackage

// File: rtl/flash_reg_if.sv
module flash_reg_if
  import flash_ctrl_pkg::*;
#(
  parameter int BUS_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic              flag_lock,
  input  logic              flag_inval,
  output logic              unlocked,
  output logic              wren,
  output logic [31:0]       addr_buf,
  output logic [31:0]       wdata_reg,
  output logic              load_req,
  output logic              erase_req,
  output logic              prog_req
);
  logic        unlocked_n, wren_n;
  logic [31:0] addr_buf_n, wdata_reg_n;
  logic        wr;
  logic        hit_wctrl, hit_cmd, hit_addrb, hit_wdata, hit_status, hit_lock;

  assign wr         = bus_en && bus_we;
  assign hit_wctrl  = (bus_addr == BUS_AW'(OFS_WCTRL));
  assign hit_cmd    = (bus_addr == BUS_AW'(OFS_CMD));
  assign hit_addrb  = (bus_addr == BUS_AW'(OFS_ADDRB));
  assign hit_wdata  = (bus_addr == BUS_AW'(OFS_WDATA));
  assign hit_status = (bus_addr == BUS_AW'(OFS_STATUS));
  assign hit_lock   = (bus_addr == BUS_AW'(OFS_LOCK));

  // Command decode: load wins outright, erase wins over program.
  always_comb begin
    load_req  = 1'b0;
    erase_req = 1'b0;
    prog_req  = 1'b0;
    if (wr && hit_cmd && unlocked) begin
      if (bus_wdata[CMD_LOAD])       load_req  = 1'b1;
      else if (bus_wdata[CMD_ERASE]) erase_req = 1'b1;
      else if (bus_wdata[CMD_PROG])  prog_req  = 1'b1;
    end
  end

  always_comb begin
    unlocked_n  = unlocked;
    wren_n      = wren;
    addr_buf_n  = addr_buf;
    wdata_reg_n = wdata_reg;
    if (wr) begin
      if (hit_lock)               unlocked_n  = (bus_wdata[15:0] == UNLOCK_KEY);
      if (hit_wctrl && unlocked)  wren_n      = bus_wdata[0];
      if (hit_addrb && unlocked)  addr_buf_n  = bus_wdata;
      if (hit_wdata && unlocked)  wdata_reg_n = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked  <= 1'b0;
      wren      <= 1'b0;
      addr_buf  <= '0;
      wdata_reg <= '0;
    end else begin
      unlocked  <= unlocked_n;
      wren      <= wren_n;
      addr_buf  <= addr_buf_n;
      wdata_reg <= wdata_reg_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_wctrl)  bus_rdata = {31'b0, wren};
    if (hit_addrb)  bus_rdata = addr_buf;
    if (hit_wdata)  bus_rdata = wdata_reg;
    if (hit_status) bus_rdata = {26'b0, 1'b0, 1'b0, !busy, flag_inval, flag_lock, busy};
    if (hit_lock)   bus_rdata = {31'b0, !unlocked};
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_ctrl_pkg::*;
#(
  parameter int PAGE_WORDS = 8,
  parameter int NUM_PAGES  = 4,
  parameter int ERASE_CYC  = 12,
  parameter int PROG_CYC   = 5,
  localparam int PAGE_AW   = $clog2(PAGE_WORDS),
  localparam int PG_AW     = $clog2(NUM_PAGES),
  localparam int WORD_AW   = PAGE_AW + PG_AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_req,
  input  logic                 erase_req,
  input  logic                 prog_req,
  input  logic                 wren,
  input  logic [31:0]          addr_buf,
  input  logic [31:0]          wdata_reg,
  input  logic [NUM_PAGES-1:0] page_ok,
  output logic                 busy,
  output logic                 flag_lock,
  output logic                 flag_inval,
  output logic [31:0]          int_addr,
  output logic                 arr_erase,
  output logic                 arr_prog,
  output logic [WORD_AW-1:0]   arr_word,
  output logic [31:0]          arr_data
);
  localparam int MAXC          = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W         = $clog2(MAXC + 1);
  localparam int TOTAL_BYTES   = NUM_PAGES * PAGE_WORDS * 4;
  localparam int PG_LSB        = 2 + PAGE_AW;

  flash_op_e        op, op_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             busy_n, flag_lock_n, flag_inval_n;
  logic [31:0]      int_addr_n, pdata, pdata_n, step_addr;
  logic             start_ok, last_cyc;
  logic [1:0]       chk_load, chk_step;

  // {invalid, locked} for a byte address
  function automatic logic [1:0] addr_check(input logic [31:0] a,
                                            input logic [NUM_PAGES-1:0] ok);
    logic             inv;
    logic [PG_AW-1:0] pg;
    inv = (a >= 32'(TOTAL_BYTES));
    pg  = a[PG_LSB +: PG_AW];
    return {inv, !inv && !ok[pg]};
  endfunction

  assign step_addr = int_addr + 32'd4;
  assign chk_load  = addr_check(addr_buf, page_ok);
  assign chk_step  = addr_check(step_addr, page_ok);
  assign start_ok  = wren && !busy && !flag_inval && !flag_lock;
  assign last_cyc  = busy && (cnt == '0);

  always_comb begin
    op_n         = op;
    cnt_n        = cnt;
    busy_n       = busy;
    flag_lock_n  = flag_lock;
    flag_inval_n = flag_inval;
    int_addr_n   = int_addr;
    pdata_n      = pdata;
    if (busy) begin
      if (last_cyc) begin
        busy_n = 1'b0;
        op_n   = OP_IDLE;
        if (op == OP_PROG) begin
          int_addr_n   = step_addr;
          flag_inval_n = chk_step[1];
          flag_lock_n  = chk_step[0];
        end
      end else begin
        cnt_n = cnt - 1'b1;
      end
    end else if (load_req) begin
      int_addr_n   = {addr_buf[31:2], 2'b00};
      flag_inval_n = chk_load[1];
      flag_lock_n  = chk_load[0];
    end else if (erase_req && start_ok) begin
      busy_n = 1'b1;
      op_n   = OP_ERASE;
      cnt_n  = CNT_W'(ERASE_CYC - 1);
    end else if (prog_req && start_ok) begin
      busy_n  = 1'b1;
      op_n    = OP_PROG;
      cnt_n   = CNT_W'(PROG_CYC - 1);
      pdata_n = wdata_reg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op         <= OP_IDLE;
      cnt        <= '0;
      busy       <= 1'b0;
      flag_lock  <= 1'b0;
      flag_inval <= 1'b0;
      int_addr   <= '0;
      pdata      <= '0;
    end else begin
      op         <= op_n;
      cnt        <= cnt_n;
      busy       <= busy_n;
      flag_lock  <= flag_lock_n;
      flag_inval <= flag_inval_n;
      int_addr   <= int_addr_n;
      pdata      <= pdata_n;
    end
  end

  assign arr_erase = last_cyc && (op == OP_ERASE);
  assign arr_prog  = last_cyc && (op == OP_PROG);
  assign arr_word  = int_addr[2 +: WORD_AW];
  assign arr_data  = pdata;
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
  parameter int PAGE_WORDS = 8,
  parameter int NUM_PAGES  = 4,
  localparam int PAGE_AW   = $clog2(PAGE_WORDS),
  localparam int PG_AW     = $clog2(NUM_PAGES),
  localparam int WORD_AW   = PAGE_AW + PG_AW,
  localparam int WORDS     = PAGE_WORDS * NUM_PAGES
) (
  input  logic               clk,
  input  logic               erase,
  input  logic               prog,
  input  logic [WORD_AW-1:0] word,
  input  logic [31:0]        data,
  input  logic [WORD_AW-1:0] rd_addr,
  output logic [31:0]        rd_data
);
  logic [31:0]      mem [WORDS];
  logic [PG_AW-1:0] page;

  assign page = word[PAGE_AW +: PG_AW];

  // Erase fills a page with ones; program can only clear bits.
  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < PAGE_WORDS; i++) begin
        mem[{page, PAGE_AW'(i)}] <= '1;
      end
    end else if (prog) begin
      mem[word] <= mem[word] & data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int BUS_AW     = 8,
  parameter int PAGE_WORDS = 8,
  parameter int NUM_PAGES  = 4,
  parameter int ERASE_CYC  = 12,
  parameter int PROG_CYC   = 5
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      bus_en,
  input  logic                                      bus_we,
  input  logic [BUS_AW-1:0]                         bus_addr,
  input  logic [31:0]                               bus_wdata,
  output logic [31:0]                               bus_rdata,
  input  logic [NUM_PAGES-1:0]                      page_wr_ok,
  input  logic [$clog2(NUM_PAGES*PAGE_WORDS)-1:0]   arr_raddr,
  output logic [31:0]                               arr_rdata
);
  localparam int WORD_AW = $clog2(NUM_PAGES * PAGE_WORDS);

  logic               unlocked, wren, load_req, erase_req, prog_req;
  logic [31:0]        addr_buf, wdata_reg, int_addr, arr_data;
  logic               busy, flag_lock, flag_inval, arr_erase, arr_prog;
  logic [WORD_AW-1:0] arr_word;

  flash_reg_if #(.BUS_AW(BUS_AW)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .flag_lock(flag_lock), .flag_inval(flag_inval),
    .unlocked(unlocked), .wren(wren), .addr_buf(addr_buf), .wdata_reg(wdata_reg),
    .load_req(load_req), .erase_req(erase_req), .prog_req(prog_req)
  );

  flash_seq #(
    .PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES),
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
  ) i_seq (
    .clk(clk), .rst_n(rst_n),
    .load_req(load_req), .erase_req(erase_req), .prog_req(prog_req),
    .wren(wren), .addr_buf(addr_buf), .wdata_reg(wdata_reg), .page_ok(page_wr_ok),
    .busy(busy), .flag_lock(flag_lock), .flag_inval(flag_inval), .int_addr(int_addr),
    .arr_erase(arr_erase), .arr_prog(arr_prog), .arr_word(arr_word), .arr_data(arr_data)
  );

  flash_array_model #(.PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES)) i_array (
    .clk(clk), .erase(arr_erase), .prog(arr_prog), .word(arr_word),
    .data(arr_data), .rd_addr(arr_raddr), .rd_data(arr_rdata)
  );
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int ERASE_CYC = 12,
  parameter int PROG_CYC  = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        unlocked,
  input logic        wren,
  input logic [31:0] addr_buf,
  input logic        busy,
  input logic        flag_lock,
  input logic        flag_inval,
  input logic [31:0] int_addr,
  input logic        arr_prog
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  a_r2_frozen_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(addr_buf));
  a_r2_frozen_wren: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(wren));
  a_r3_start_needs_wren: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wren));
  a_r5_start_needs_clean_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!flag_lock && !flag_inval));
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_lock && flag_inval));
  a_r9_step_by_word: assert property (@(posedge clk) disable iff (!rst_n)
    arr_prog |=> (int_addr == $past(int_addr) + 32'd4));
  a_r8_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= MAXC);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) i_chk (
  .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .wren(wren), .addr_buf(addr_buf),
  .busy(busy), .flag_lock(flag_lock), .flag_inval(flag_inval),
  .int_addr(int_addr), .arr_prog(arr_prog)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int NP = 4;
  localparam int EC = 12;
  localparam int PC = 5;
  localparam int WAW = $clog2(PW * NP);
  localparam logic [7:0] WC = 8'h08, CMD = 8'h0C, AB = 8'h10, WD = 8'h18, ST = 8'h1C, LK = 8'h3C;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bus_en, bus_we;
  logic [7:0]     bus_addr;
  logic [31:0]    bus_wdata, bus_rdata, arr_rdata;
  logic [NP-1:0]  page_wr_ok;
  logic [WAW-1:0] arr_raddr;

  int errors = 0;
  int checks = 0;
  int n;

  typedef struct {
    int          idx;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(.BUS_AW(8), .PAGE_WORDS(PW), .NUM_PAGES(NP), .ERASE_CYC(EC), .PROG_CYC(PC))
  i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .page_wr_ok(page_wr_ok),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata)
  );

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    cmp(tag, bus_rdata, exp);
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    bus_addr = ST;
    #1;
    while (bus_rdata[0]) begin
      cyc++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic push(input int idx, input logic [31:0] exp, input string tag);
    sb_item_t it;
    it.idx = idx; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic drain;
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares array words against queued expectations.
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() != 0) begin
        sb_item_t it;
        it = sbq.pop_front();
        arr_raddr = WAW'(it.idx);
        #2;
        cmp(it.tag, arr_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    page_wr_ok = 4'b1011; arr_raddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd_chk(ST, 32'h8, "R1 status");
    rd_chk(LK, 32'h1, "R1 lock");
    rd_chk(WC, 32'h0, "R1 wctrl");

    // R2 frozen writes
    wr(WC, 32'h1); wr(AB, 32'h44); wr(WD, 32'hDEAD); wr(CMD, 32'h2);
    rd_chk(WC, 32'h0, "R2 frozen wctrl");
    rd_chk(AB, 32'h0, "R2 frozen addrb");
    rd_chk(WD, 32'h0, "R2 frozen wdata");
    rd_chk(ST, 32'h8, "R2 frozen cmd");
    wr(LK, 32'h1B70);
    rd_chk(LK, 32'h1, "R2 wrong key");
    wr(LK, 32'h1B71);
    rd_chk(LK, 32'h0, "R2 key");

    // R3 no write enable
    wr(AB, 32'h0); wr(CMD, 32'h1); wr(CMD, 32'h2);
    rd_chk(ST, 32'h8, "R3 erase without wren");
    wr(WC, 32'h1);
    rd_chk(WC, 32'h1, "R3 wren readback");

    // R6 erase page 0 from unaligned address
    wr(AB, 32'h07); wr(CMD, 32'h1);
    rd_chk(ST, 32'h8, "R4 valid load");
    wr(CMD, 32'h2);
    wait_idle(n);
    cmp("R6 erase busy cycles", n, EC);
    for (int i = 0; i < PW; i++) push(i, 32'hFFFF_FFFF, "R6 erased word");
    drain();

    // R7 program word 1, R9 next word without reload
    wr(WD, 32'h1234_5678); wr(CMD, 32'h8);
    wait_idle(n);
    cmp("R7 program busy cycles", n, PC);
    push(1, 32'h1234_5678, "R7 programmed word");
    push(0, 32'hFFFF_FFFF, "R7 neighbour untouched");
    wr(WD, 32'hA5A5_A5A5); wr(CMD, 32'h8);
    wait_idle(n);
    push(2, 32'hA5A5_A5A5, "R9 auto-increment word");
    wr(AB, 32'h04); wr(CMD, 32'h1); wr(WD, 32'h0000_FFFF); wr(CMD, 32'h8);
    wait_idle(n);
    push(1, 32'h0000_5678, "R7 program ANDs bits");
    drain();

    // R4/R5 invalid and protected
    wr(AB, 32'h80); wr(CMD, 32'h1);
    rd_chk(ST, 32'hC, "R4 invalid flag");
    wr(CMD, 32'h8);
    rd_chk(ST, 32'hC, "R5 program refused");
    wr(CMD, 32'h2);
    rd_chk(ST, 32'hC, "R5 erase refused");
    wr(AB, 32'h7C); wr(CMD, 32'h1);
    rd_chk(ST, 32'h8, "R4 last word valid");
    wr(AB, 32'h40); wr(CMD, 32'h1);
    rd_chk(ST, 32'hA, "R4 locked flag");
    wr(CMD, 32'h2);
    rd_chk(ST, 32'hA, "R5 locked erase refused");

    // R8 busy ready and command during busy
    wr(AB, 32'h20); wr(CMD, 32'h1); wr(CMD, 32'h2);
    rd_chk(ST, 32'h1, "R8 busy not ready");
    wr(WD, 32'h0); wr(CMD, 32'h8);
    wait_idle(n);
    rd_chk(ST, 32'h8, "R8 idle after erase");
    for (int i = PW; i < 2*PW; i++) push(i, 32'hFFFF_FFFF, "R8 program in busy ignored");
    drain();

    // R9 step into protected page
    wr(WD, 32'h0F0F_0F0F); wr(AB, 32'h3C); wr(CMD, 32'h1); wr(CMD, 32'h8);
    wait_idle(n);
    rd_chk(ST, 32'hA, "R9 flags after step");
    push(15, 32'h0F0F_0F0F, "R9 last word of page");
    drain();

    // R10 combined command bits
    wr(AB, 32'h24); wr(WD, 32'h0); wr(CMD, 32'h9);
    rd_chk(ST, 32'h8, "R10 load only");
    push(9, 32'hFFFF_FFFF, "R10 no program with load");
    drain();
    wr(CMD, 32'hA);
    wait_idle(n);
    cmp("R10 erase wins", n, EC);
    push(9, 32'hFFFF_FFFF, "R10 word still erased");
    drain();

    // R2 refreeze
    wr(LK, 32'h0);
    rd_chk(LK, 32'h1, "R2 refreeze");
    wr(CMD, 32'h2);
    rd_chk(ST, 32'h8, "R2 cmd while frozen");
    wr(WC, 32'h0);
    rd_chk(WC, 32'h1, "R2 wctrl while frozen");

    rd_chk(8'h20, 32'h0, "R11 unmapped");
    rd_chk(CMD, 32'h0, "R11 command reads zero");

    report();
  end
endmodule